// File: doc/BRIEF.md
# Serial Memory Command Engine Access Arbiter

This block shares one serial memory command engine between two requesters. One is a read path that executes code in place (XIP) straight from the memory. The other is a register-driven (MMIO) path that issues a run of command words, the final one carrying a last flag. The engine, its FIFOs and the bus fabric are outside the block. Each is reduced to a request, grant, busy or flag signal.

A latched mode bit selects between two modes. In MMIO-only mode the register path is the only requester served. In arbitrated mode XIP has strict priority, except that an MMIO sequence that has already started keeps the engine until its last command. A policy bit sets how an MMIO access to an empty receive FIFO or a full transmit FIFO is answered: with an error response, or with wait states. A core enable gates the block. While it is low, XIP requests get an error. After it rises, the block waits a fixed number of interface clock cycles before it grants anything.

Top module: `xip_mmio_arb`

## Requirements
- R1: After reset, and while enable_i is low, if_ready_o, xip_gnt_o and mmio_cmd_gnt_o are 0.
- R2: if_ready_o goes to 1 after exactly RST_CYCLES (default 20) rising clock edges with enable_i held high. No grant is given while if_ready_o is 0.
- R3: With the latched mode at 0 (MMIO-only), xip_gnt_o stays 0 and an MMIO command request is granted in the same cycle.
- R4: With the latched mode at 1, an XIP request is granted in the same cycle it is raised when no MMIO sequence holds the engine. An XIP request beats a simultaneous MMIO request. A new MMIO sequence is not started while eng_busy_i is 1. The two grants are never high together.
- R5: After an MMIO command is granted with mmio_cmd_last_i at 0, XIP is not granted until an MMIO command with mmio_cmd_last_i at 1 has been granted.
- R6: A pending MMIO request is granted in the first cycle in which no XIP request is pending and eng_busy_i is 0.
- R7: With stall_mode_i at 0, an MMIO access (mmio_acc_rd_i=1 read with rx_empty_i=1, or mmio_acc_rd_i=0 write with tx_full_i=1) asserts mmio_acc_err_o in the same cycle. A read ignores tx_full_i and a write ignores rx_empty_i.
- R8: With stall_mode_i at 1, the same blocked access asserts mmio_acc_wait_o instead. An access that is not blocked asserts mmio_acc_ok_o. At most one of the three responses is high.
- R9: While enable_i is 0, an XIP request asserts xip_err_o in the same cycle and is not granted.
- R10: busy_o is 1 when either grant is high, when an MMIO sequence holds the engine, or when eng_busy_i is 1. Otherwise it is 0.
- R11: arb_mode_i is latched on every rising edge at which busy_o is 0 and is ignored on edges at which busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Core enable |
| arb_mode_i | input | 1 | 0 MMIO-only, 1 arbitrated |
| stall_mode_i | input | 1 | Blocked FIFO access policy: 0 error, 1 wait states |
| if_ready_o | output | 1 | Interface released from startup reset |
| busy_o | output | 1 | Arbiter or engine busy |
| eng_busy_i | input | 1 | Engine has a transfer in flight |
| xip_req_i | input | 1 | XIP request |
| xip_gnt_o | output | 1 | XIP grant |
| xip_err_o | output | 1 | XIP error response (core disabled) |
| mmio_cmd_req_i | input | 1 | MMIO command word request |
| mmio_cmd_last_i | input | 1 | Command word ends the MMIO sequence |
| mmio_cmd_gnt_o | output | 1 | MMIO command grant |
| mmio_acc_i | input | 1 | MMIO FIFO access valid |
| mmio_acc_rd_i | input | 1 | 1 receive FIFO read, 0 transmit FIFO write |
| rx_empty_i | input | 1 | Receive FIFO empty |
| tx_full_i | input | 1 | Transmit FIFO full |
| mmio_acc_ok_o | output | 1 | Access accepted |
| mmio_acc_wait_o | output | 1 | Access held with a wait state |
| mmio_acc_err_o | output | 1 | Access answered with an error |

## Verification
Grants, XIP errors, FIFO responses and busy_o are combinational from inputs and registered state. The bench therefore drives on the falling edge and samples 1 ns later, in the same cycle. Sequence ownership and the latched mode change on the next rising edge, so their effects are checked one cycle after the grant or mode change that causes them. if_ready_o is checked after exactly RST_CYCLES−1 and RST_CYCLES rising edges with enable high, which pins the startup count to the edge.

// File: rtl/xip_mmio_arb_pkg.sv
package xip_mmio_arb_pkg;
  typedef enum logic [1:0] {
    RESP_IDLE = 2'd0,
    RESP_OK   = 2'd1,
    RESP_WAIT = 2'd2,
    RESP_ERR  = 2'd3
  } acc_resp_e;
endpackage

// File: rtl/xm_ready_timer.sv
module xm_ready_timer #(
  parameter int unsigned RST_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic ready_o
);
  if (RST_CYCLES == 0) begin : g_nodelay
    assign ready_o = enable_i;
  end else begin : g_count
    localparam int unsigned CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RST_CYCLES);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (!enable_i)     cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign ready_o = enable_i && (cnt_q == LIMIT);
  end
endmodule

// File: rtl/xm_arb_core.sv
module xm_arb_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic ready_i,
  input  logic arb_mode_i,
  input  logic eng_busy_i,
  input  logic xip_req_i,
  input  logic mmio_req_i,
  input  logic mmio_last_i,
  output logic xip_gnt_o,
  output logic mmio_gnt_o,
  output logic busy_o,
  output logic mode_o,
  output logic mmio_own_o
);
  logic mode_q, own_q;
  logic mmio_start;

  // new MMIO sequence: engine idle and, when arbitrating, no XIP pending
  assign mmio_start = !eng_busy_i && (!mode_q || !xip_req_i);
  assign mmio_gnt_o = ready_i && mmio_req_i && (own_q || mmio_start);
  assign xip_gnt_o  = ready_i && mode_q && xip_req_i && !own_q;
  assign busy_o     = own_q || eng_busy_i || xip_gnt_o || mmio_gnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        own_q <= 1'b0;
    else if (!enable_i) own_q <= 1'b0;
    else if (mmio_gnt_o) own_q <= !mmio_last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= 1'b0;
    else if (!busy_o) mode_q <= arb_mode_i;
  end

  assign mode_o     = mode_q;
  assign mmio_own_o = own_q;
endmodule

// File: rtl/xm_fifo_guard.sv
module xm_fifo_guard
  import xip_mmio_arb_pkg::*;
(
  input  logic      acc_i,
  input  logic      rd_i,
  input  logic      rx_empty_i,
  input  logic      tx_full_i,
  input  logic      stall_mode_i,
  output acc_resp_e resp_o
);
  logic blocked;
  assign blocked = rd_i ? rx_empty_i : tx_full_i;

  always_comb begin
    if (!acc_i)            resp_o = RESP_IDLE;
    else if (!blocked)     resp_o = RESP_OK;
    else if (stall_mode_i) resp_o = RESP_WAIT;
    else                   resp_o = RESP_ERR;
  end
endmodule

// File: rtl/xip_mmio_arb.sv
module xip_mmio_arb
  import xip_mmio_arb_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic arb_mode_i,
  input  logic stall_mode_i,
  output logic if_ready_o,
  output logic busy_o,
  input  logic eng_busy_i,
  input  logic xip_req_i,
  output logic xip_gnt_o,
  output logic xip_err_o,
  input  logic mmio_cmd_req_i,
  input  logic mmio_cmd_last_i,
  output logic mmio_cmd_gnt_o,
  input  logic mmio_acc_i,
  input  logic mmio_acc_rd_i,
  input  logic rx_empty_i,
  input  logic tx_full_i,
  output logic mmio_acc_ok_o,
  output logic mmio_acc_wait_o,
  output logic mmio_acc_err_o
);
  logic      ready;
  logic      mode_q;
  logic      mmio_own_q;
  acc_resp_e resp;

  xm_ready_timer #(.RST_CYCLES(RST_CYCLES)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .ready_o  (ready)
  );

  xm_arb_core i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .ready_i     (ready),
    .arb_mode_i  (arb_mode_i),
    .eng_busy_i  (eng_busy_i),
    .xip_req_i   (xip_req_i),
    .mmio_req_i  (mmio_cmd_req_i),
    .mmio_last_i (mmio_cmd_last_i),
    .xip_gnt_o   (xip_gnt_o),
    .mmio_gnt_o  (mmio_cmd_gnt_o),
    .busy_o      (busy_o),
    .mode_o      (mode_q),
    .mmio_own_o  (mmio_own_q)
  );

  xm_fifo_guard i_guard (
    .acc_i        (mmio_acc_i),
    .rd_i         (mmio_acc_rd_i),
    .rx_empty_i   (rx_empty_i),
    .tx_full_i    (tx_full_i),
    .stall_mode_i (stall_mode_i),
    .resp_o       (resp)
  );

  assign if_ready_o      = ready;
  assign xip_err_o       = xip_req_i && !enable_i;
  assign mmio_acc_ok_o   = (resp == RESP_OK);
  assign mmio_acc_wait_o = (resp == RESP_WAIT);
  assign mmio_acc_err_o  = (resp == RESP_ERR);
endmodule

// File: rtl/xip_mmio_arb_chk.sv
module xip_mmio_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic stall_mode_i,
  input logic if_ready_o,
  input logic busy_o,
  input logic eng_busy_i,
  input logic xip_req_i,
  input logic xip_gnt_o,
  input logic xip_err_o,
  input logic mmio_cmd_req_i,
  input logic mmio_cmd_last_i,
  input logic mmio_cmd_gnt_o,
  input logic mmio_acc_i,
  input logic mmio_acc_rd_i,
  input logic rx_empty_i,
  input logic tx_full_i,
  input logic mmio_acc_ok_o,
  input logic mmio_acc_wait_o,
  input logic mmio_acc_err_o,
  input logic mode_q
);
  logic blocked;
  assign blocked = mmio_acc_rd_i ? rx_empty_i : tx_full_i;

  assert_one_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xip_gnt_o, mmio_cmd_gnt_o}));

  assert_seq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_cmd_gnt_o && !mmio_cmd_last_i) |=> !xip_gnt_o);

  assert_no_xip_mode0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !xip_gnt_o);

  assert_gate_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_ready_o |-> (!xip_gnt_o && !mmio_cmd_gnt_o));

  assert_ready_needs_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_ready_o |-> enable_i);

  assert_xip_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xip_req_i && !enable_i) |-> (xip_err_o && !xip_gnt_o));

  assert_err_policy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_acc_i && blocked && !stall_mode_i) |-> mmio_acc_err_o);

  assert_wait_policy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_acc_i && blocked && stall_mode_i) |-> mmio_acc_wait_o);

  assert_resp_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mmio_acc_ok_o, mmio_acc_wait_o, mmio_acc_err_o}));

  assert_busy_cover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xip_gnt_o || mmio_cmd_gnt_o || eng_busy_i) |-> busy_o);

  assert_mode_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (mode_q == $past(mode_q)));
endmodule

bind xip_mmio_arb xip_mmio_arb_chk i_chk (.*);

// File: tb/test_xip_mmio_arb.sv
module test_xip_mmio_arb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, arb_mode_i = 1'b0, stall_mode_i = 1'b0;
  logic eng_busy_i = 1'b0, xip_req_i = 1'b0;
  logic mmio_cmd_req_i = 1'b0, mmio_cmd_last_i = 1'b0;
  logic mmio_acc_i = 1'b0, mmio_acc_rd_i = 1'b0, rx_empty_i = 1'b0, tx_full_i = 1'b0;
  logic if_ready_o, busy_o, xip_gnt_o, xip_err_o, mmio_cmd_gnt_o;
  logic mmio_acc_ok_o, mmio_acc_wait_o, mmio_acc_err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  xip_mmio_arb i_xip_mmio_arb (.*);

  // [7]acc [6]rd [5]rx_empty [4]tx_full [3]stall | [2]ok [1]wait [0]err
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    8'b11100_001, 8'b11101_010, 8'b11010_100, 8'b10010_001,
    8'b10011_010, 8'b10101_100, 8'b01110_000, 8'b10000_100
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 ready after reset", if_ready_o, 0);
    chk("R1 grants after reset", {xip_gnt_o, mmio_cmd_gnt_o}, 0);
    chk("R10 idle busy", busy_o, 0);

    // FIFO response table (R7, R8)
    for (int i = 0; i < NV; i++) begin
      {mmio_acc_i, mmio_acc_rd_i, rx_empty_i, tx_full_i, stall_mode_i} = VEC[i][7:3];
      #1;
      chk(VEC[i][3] ? "R8 fifo response" : "R7 fifo response",
          {mmio_acc_ok_o, mmio_acc_wait_o, mmio_acc_err_o}, VEC[i][2:0]);
    end
    {mmio_acc_i, mmio_acc_rd_i, rx_empty_i, tx_full_i, stall_mode_i} = '0;

    // R9: disabled XIP error
    @(negedge clk_i);
    xip_req_i = 1'b1;
    #1;
    chk("R9 xip err when disabled", {xip_err_o, xip_gnt_o}, 2'b10);
    xip_req_i = 1'b0;

    // R2: startup count
    @(negedge clk_i);
    enable_i = 1'b1;
    repeat (19) step();
    mmio_cmd_req_i = 1'b1; mmio_cmd_last_i = 1'b1;
    #1;
    chk("R2 not ready at 19", if_ready_o, 0);
    chk("R2 no grant before ready", mmio_cmd_gnt_o, 0);
    mmio_cmd_req_i = 1'b0;
    step();
    chk("R2 ready at 20", if_ready_o, 1);

    // R3: mode 0
    mmio_cmd_req_i = 1'b1; xip_req_i = 1'b1;
    #1;
    chk("R3 mmio granted in mode 0", mmio_cmd_gnt_o, 1);
    chk("R3 xip not granted in mode 0", xip_gnt_o, 0);
    mmio_cmd_req_i = 1'b0; xip_req_i = 1'b0;
    @(negedge clk_i);
    arb_mode_i = 1'b1;
    step();

    // R4: mode 1 priority
    xip_req_i = 1'b1;
    #1;
    chk("R4 xip same cycle", xip_gnt_o, 1);
    mmio_cmd_req_i = 1'b1; mmio_cmd_last_i = 1'b0;
    #1;
    chk("R4 xip beats mmio", {xip_gnt_o, mmio_cmd_gnt_o}, 2'b10);
    chk("R10 busy on grant", busy_o, 1);
    xip_req_i = 1'b0;
    #1;
    chk("R6 mmio on first free cycle", mmio_cmd_gnt_o, 1);
    step();

    // R5: sequence held
    mmio_cmd_req_i = 1'b0; xip_req_i = 1'b1;
    #1;
    chk("R5 xip waits mid-sequence", xip_gnt_o, 0);
    chk("R10 busy while owned", busy_o, 1);
    arb_mode_i = 1'b0;
    step();
    mmio_cmd_req_i = 1'b1; mmio_cmd_last_i = 1'b1;
    #1;
    chk("R5 last command granted", {xip_gnt_o, mmio_cmd_gnt_o}, 2'b01);
    step();
    mmio_cmd_req_i = 1'b0; mmio_cmd_last_i = 1'b0;
    #1;
    chk("R11 mode kept while busy", xip_gnt_o, 1);
    xip_req_i = 1'b0; arb_mode_i = 1'b1;
    #1;
    chk("R10 idle again", busy_o, 0);
    step();

    // engine busy blocks MMIO start
    eng_busy_i = 1'b1; mmio_cmd_req_i = 1'b1; mmio_cmd_last_i = 1'b1;
    #1;
    chk("R10 busy from engine", busy_o, 1);
    chk("R4 engine busy blocks mmio start", mmio_cmd_gnt_o, 0);
    eng_busy_i = 1'b0;
    #1;
    chk("R6 mmio when engine idle", mmio_cmd_gnt_o, 1);
    mmio_cmd_req_i = 1'b0; mmio_cmd_last_i = 1'b0;

    // disable again
    @(negedge clk_i);
    enable_i = 1'b0;
    step();
    xip_req_i = 1'b1;
    #1;
    chk("R1 ready drops when disabled", if_ready_o, 0);
    chk("R9 xip err after disable", {xip_err_o, xip_gnt_o}, 2'b10);
    xip_req_i = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule